// File: doc/BRIEF.md
# Thermal Foldback Controller

This block turns a thermal warning into an attenuation value for the audio gain path. While the warning is present, the attenuation climbs one 0.5 dB step per interval. Because the interval is fixed by a selectable delay code, the total cut grows with how long the part has been running hot rather than jumping to a constant amount. When the warning goes away, the cut is released the same way, one step per interval, until it returns to zero.

The warning can come from an on-chip flag or from a board-level pin. The pin is synchronised with two flops. After that, both sources are treated exactly alike. An enable input gates the whole function. The output is a step count in 0.5 dB units, and a downstream multiplier applies it to the signal.

Top module: `thermal_foldback`

## Requirements
- R1: While the effective warning is 1 and `fold_en` is 1, `atten_half_db` never decreases, and it rises by exactly 1 (one 0.5 dB unit) at the end of each interval.
- R2: The interval length in clock cycles is L = CYC_PER_HALF_SEC × m. The multiplier m is 1 for `dly_code` 00, 2 for 01 and 3 for 10. After the effective warning changes level, the first step in the new direction occurs on the (L+1)-th rising edge that samples the new level. Later steps follow every L edges while the level holds. A level change on the edge where a step would have fallen cancels that step and restarts the interval.
- R3: `atten_half_db` saturates at MAX_STEPS (default 60) and never exceeds it.
- R4: While the effective warning is 0 and `fold_en` is 1, the attenuation falls by 1 per interval (same L as R2) until it reaches 0, and then stays at 0.
- R5: When `src_ext` is 1, the effective warning is `warn_ext_pin` delayed by two clock edges. Beyond that delay, it behaves exactly as the internal flag does. When `src_ext` is 0, `warn_int` is used on the edge that samples it.
- R6: When `fold_en` is 0, `atten_half_db` is 0 after the next edge and stays 0. After re-enable with the warning unchanged, the first step comes L edges later.
- R7: A change of `dly_code` takes effect at once. If the elapsed time in the current interval already meets or exceeds the new length, the step falls on the next edge.
- R8: A synchronous active-high `rst` clears the attenuation to 0 and restarts the interval timing.
- R9: The warning source that is not selected has no effect on `atten_half_db`.
- R10: Code 11 selects the same interval as code 10 (m = 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fold_en | input | 1 | Foldback enable; 0 forces zero attenuation |
| src_ext | input | 1 | 1 selects the external warning pin, 0 selects the internal flag |
| warn_int | input | 1 | Internal thermal warning flag, active high |
| warn_ext_pin | input | 1 | External thermal warning pin, active high, asynchronous |
| dly_code | input | 2 | Step interval select: 00 = 1x, 01 = 2x, 10/11 = 3x CYC_PER_HALF_SEC cycles |
| atten_half_db | output | $clog2(MAX_STEPS+1) | Attenuation in 0.5 dB steps |

## Verification
A step that is due can land on the same edge as a change of warning level or a drop of the enable. The bench provokes the level-change case by reversing the warning exactly 2L edges after it first rose. That is the edge where the second attack step would fall. The bench also shortens the delay code while an interval is already past the new length, so that the step and the code change coincide. A cycle-level reference model in the bench, written from R2, R6 and R7, predicts the outcome. The scoreboard compares its prediction with the output on every cycle: the step must be cancelled by the restart, or forced by the shortened interval.

// File: rtl/tf_pkg.sv
package tf_pkg;

    typedef enum logic [1:0] {
        DLY_SHORT    = 2'b00,
        DLY_MID      = 2'b01,
        DLY_LONG     = 2'b10,
        DLY_LONG_ALT = 2'b11
    } dly_sel_e;

    typedef enum logic {
        DIR_RELEASE = 1'b0,
        DIR_ATTACK  = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        logic      step;
        ramp_dir_e dir;
    } step_evt_t;

    // Interval length in units of the half-second base period
    function automatic int unsigned interval_mult(dly_sel_e sel);
        case (sel)
            DLY_SHORT: return 1;
            DLY_MID:   return 2;
            default:   return 3;
        endcase
    endfunction

endpackage

// File: rtl/tf_warn_src.sv
module tf_warn_src (
    input  logic clk,
    input  logic rst,
    input  logic src_ext,
    input  logic warn_int,
    input  logic warn_ext_pin,
    output logic warn_eff
);
    logic [1:0] sync_q;
    logic [1:0] rst_hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            rst_hist_q <= '0;
        end else begin
            sync_q     <= {sync_q[0], warn_ext_pin};
            rst_hist_q <= {rst_hist_q[0], 1'b1};
        end
    end

    assign warn_eff = src_ext ? sync_q[1] : warn_int;

    // R5: external pin reaches the ramp logic two edges later
    assert_ext_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (src_ext && rst_hist_q[1]) |-> (warn_eff == $past(warn_ext_pin, 2)));

endmodule

// File: rtl/tf_step_timer.sv
module tf_step_timer
    import tf_pkg::*;
#(
    parameter int unsigned CYC_PER_HALF_SEC = 12_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      warn,
    input  logic [1:0] dly_code,
    input  logic      at_max,
    input  logic      at_zero,
    output step_evt_t evt
);
    localparam int unsigned LEN_MAX = CYC_PER_HALF_SEC * 3;
    localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);
    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(CYC_PER_HALF_SEC * interval_mult(DLY_SHORT));
    localparam logic [CNT_W-1:0] LEN_M = CNT_W'(CYC_PER_HALF_SEC * interval_mult(DLY_MID));
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(CYC_PER_HALF_SEC * interval_mult(DLY_LONG));

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;
    logic             dir_q;
    logic             idle;
    logic             restart;

    always_comb begin
        case (dly_sel_e'(dly_code))
            DLY_SHORT: len = LEN_S;
            DLY_MID:   len = LEN_M;
            default:   len = LEN_L;
        endcase
    end

    assign idle    = (warn && at_max) || (!warn && at_zero);
    assign restart = !en || (warn != dir_q) || idle;

    always_comb begin
        evt.dir  = warn ? DIR_ATTACK : DIR_RELEASE;
        evt.step = !restart && (cnt_q >= len - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            dir_q <= warn;
            if (restart || evt.step) cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: elapsed count never runs past the longest interval
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q < LEN_L);

    // R2: a level change of the warning never yields a step on the next edge
    assert_no_early_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && warn != dir_q) |=> (cnt_q == '0));

endmodule

// File: rtl/tf_atten_acc.sv
module tf_atten_acc
    import tf_pkg::*;
#(
    parameter int unsigned MAX_STEPS = 60,
    localparam int unsigned ATT_W    = $clog2(MAX_STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  step_evt_t        evt,
    output logic [ATT_W-1:0] att,
    output logic             at_max,
    output logic             at_zero
);
    localparam logic [ATT_W-1:0] ATT_TOP = ATT_W'(MAX_STEPS);

    logic [ATT_W-1:0] att_q;

    assign att     = att_q;
    assign at_max  = (att_q == ATT_TOP);
    assign at_zero = (att_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            att_q <= '0;
        end else if (evt.step) begin
            if (evt.dir == DIR_ATTACK) att_q <= att_q + 1'b1;
            else                       att_q <= att_q - 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        att_q <= ATT_TOP);

    assert_attack_monotone_R1: assert property (@(posedge clk) disable iff (rst)
        (en && evt.dir == DIR_ATTACK) |=> (att_q >= $past(att_q)));

    assert_release_monotone_R4: assert property (@(posedge clk) disable iff (rst)
        (en && evt.dir == DIR_RELEASE) |=> (att_q <= $past(att_q)));

    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (att_q == '0));

endmodule

// File: rtl/thermal_foldback.sv
module thermal_foldback
    import tf_pkg::*;
#(
    parameter int unsigned CYC_PER_HALF_SEC = 12_000_000,
    parameter int unsigned MAX_STEPS        = 60
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               fold_en,
    input  logic                               src_ext,
    input  logic                               warn_int,
    input  logic                               warn_ext_pin,
    input  logic [1:0]                         dly_code,
    output logic [$clog2(MAX_STEPS+1)-1:0]     atten_half_db
);
    localparam int unsigned ATT_W = $clog2(MAX_STEPS + 1);

    logic       warn_eff;
    logic       at_max;
    logic       at_zero;
    step_evt_t  evt;
    logic [ATT_W-1:0] att;

    tf_warn_src u_src (
        .clk          (clk),
        .rst          (rst),
        .src_ext      (src_ext),
        .warn_int     (warn_int),
        .warn_ext_pin (warn_ext_pin),
        .warn_eff     (warn_eff)
    );

    tf_step_timer #(.CYC_PER_HALF_SEC(CYC_PER_HALF_SEC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (fold_en),
        .warn     (warn_eff),
        .dly_code (dly_code),
        .at_max   (at_max),
        .at_zero  (at_zero),
        .evt      (evt)
    );

    tf_atten_acc #(.MAX_STEPS(MAX_STEPS)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (fold_en),
        .evt     (evt),
        .att     (att),
        .at_max  (at_max),
        .at_zero (at_zero)
    );

    assign atten_half_db = att;

    // R8: reset leaves the output cleared
    assert_reset_zero_R8: assert property (@(posedge clk)
        rst |=> (atten_half_db == '0));

endmodule

// File: tb/thermal_foldback_bench.sv
`timescale 1ns/1ps
module thermal_foldback_bench;
    localparam int HALF = 3;
    localparam int MAXS = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fold_en = 1'b0;
    logic       src_ext = 1'b0;
    logic       warn_int = 1'b0;
    logic       warn_ext_pin = 1'b0;
    logic [1:0] dly_code = 2'b01;
    logic [5:0] atten_half_db;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R8";

    int    exp_q[$];
    string tag_q[$];

    int m_att = 0, m_cnt = 0, m_dir = 0, m_s1 = 0, m_s2 = 0;

    always #2 clk = ~clk;

    thermal_foldback #(.CYC_PER_HALF_SEC(HALF), .MAX_STEPS(MAXS)) u_thermal_foldback (
        .clk          (clk),
        .rst          (rst),
        .fold_en      (fold_en),
        .src_ext      (src_ext),
        .warn_int     (warn_int),
        .warn_ext_pin (warn_ext_pin),
        .dly_code     (dly_code),
        .atten_half_db(atten_half_db)
    );

    function automatic int len_of(logic [1:0] c);
        // R2 / R10: multipliers 1, 2, 3, 3
        return HALF * ((c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 3);
    endfunction

    // Reference model, updated on each rising edge
    always @(posedge clk) begin
        int w, l;
        bit idle;
        if (rst) begin
            m_att = 0; m_cnt = 0; m_dir = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            w    = src_ext ? m_s2 : int'(warn_int);
            l    = len_of(dly_code);
            idle = (w == 1 && m_att == MAXS) || (w == 0 && m_att == 0);
            if (!fold_en) begin
                m_att = 0; m_cnt = 0;
            end else if (w != m_dir || idle) begin
                m_cnt = 0;
            end else if (m_cnt >= l - 1) begin
                m_cnt = 0;
                m_att = (w == 1) ? m_att + 1 : m_att - 1;
            end else begin
                m_cnt++;
            end
            m_dir = w;
            m_s2  = m_s1;
            m_s1  = int'(warn_ext_pin);
        end
        exp_q.push_back(m_att);
        tag_q.push_back(cur_tag);
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        int e;
        string t;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (int'(atten_half_db) != e) begin
                errors++;
                $display("FAIL %s: atten_half_db=%0d expected=%0d at %0t", t, atten_half_db, e, $time);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R8: reset state
        run(4);
        rst = 1'b0;
        cur_tag = "R8";
        run(3);

        // R1 / R3: long attack with code 01, into saturation
        fold_en = 1'b1;
        cur_tag = "R1";
        warn_int = 1'b1;
        run(200);
        cur_tag = "R3";
        run(250);

        // R4: release back to zero
        cur_tag = "R4";
        warn_int = 1'b0;
        run(380);

        // R2: code 00, then 10
        cur_tag = "R2";
        dly_code = 2'b00;
        warn_int = 1'b1; run(40);
        warn_int = 1'b0; run(50);
        dly_code = 2'b10;
        warn_int = 1'b1; run(60);
        warn_int = 1'b0; run(80);

        // R10: code 11 matches code 10
        cur_tag = "R10";
        dly_code = 2'b11;
        warn_int = 1'b1; run(60);
        warn_int = 1'b0; run(80);

        // R2 corner: reverse the warning on the edge where the second step is due
        cur_tag = "R2";
        dly_code = 2'b01;
        warn_int = 1'b1; run(2 * len_of(2'b01));
        warn_int = 1'b0; run(30);

        // R7: shorten the interval while the elapsed count already exceeds it
        cur_tag = "R7";
        dly_code = 2'b10;
        warn_int = 1'b1; run(len_of(2'b10) + 1 + 5);
        dly_code = 2'b00; run(20);
        warn_int = 1'b0; run(40);

        // R5 / R9: external source, internal flag toggled against it
        cur_tag = "R5";
        src_ext = 1'b1;
        dly_code = 2'b01;
        warn_ext_pin = 1'b1;
        warn_int = 1'b0;
        run(50);
        cur_tag = "R9";
        warn_int = 1'b1;
        warn_ext_pin = 1'b0;
        run(70);
        warn_ext_pin = 1'b1; run(3);
        warn_ext_pin = 1'b0; run(1);
        warn_ext_pin = 1'b1; run(40);

        // R6: disable mid-ramp, then re-enable with warning still high
        cur_tag = "R6";
        fold_en = 1'b0; run(10);
        fold_en = 1'b1; run(30);
        warn_ext_pin = 1'b0; run(60);

        // R8: reset in the middle of an attack
        cur_tag = "R8";
        src_ext = 1'b0;
        warn_int = 1'b1; run(30);
        rst = 1'b1; run(3);
        rst = 1'b0; run(20);

        finish_up();
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_up();
        end
    end

endmodule